// File: doc/BRIEF.md
# Legacy Segment Attribute Decoder

This block decides, for every CPU access in the 512 KB to 1 MB window, where the access is served and whether it may be cached. It holds seven 8-bit attribute registers that together describe fourteen segments. Each segment has a 4-bit attribute nibble: a read-routing bit, a write-routing bit, a cache-enable bit and one spare bit. The result is combinational from the current CPU address, the read/write flag and the code-fetch flag. It gives one routing decision, either system memory or PCI, and a cacheable indication.

Configuration software writes whole registers through a single-cycle write port. Accesses below 512 KB are passed through as memory-routed and cacheable. The 128 KB hole at A0000h–BFFFFh always goes to PCI. A segment that is programmed as cacheable but not readable from memory is an illegal setting. The block reports it and does not cache the segment.

Top module: `seg_attr_map`

## Requirements
- R1: After reset, register 0 holds 0Fh and registers 1 to 6 hold 00h. As a result, 80000h–9FFFFh is memory-routed and cacheable for reads and writes, and F0000h–FFFFFh and C0000h–EFFFFh are routed to PCI and are not cacheable.
- R2: Any address below 80000h routes to memory and is cacheable, and cfg_err stays low, whatever the register contents.
- R3: Any address in A0000h–BFFFFh routes to PCI and is not cacheable, whatever the register contents.
- R4: In a mapped segment, a read routes to memory when the segment's nibble bit 0 (read enable) is 1, and to PCI when it is 0.
- R5: In a mapped segment, a write routes to memory when nibble bit 1 (write enable) is 1, and to PCI when it is 0.
- R6: When nibble bits 0, 1 and 2 (cache enable) are all 1, both reads and writes to the segment are cacheable.
- R7: When the segment has read enable and cache enable set but write enable clear, it is cacheable only for reads with cpu_code high. Data reads and writes are not cacheable.
- R8: When the addressed segment has cache enable set and read enable clear, cfg_err is high and cacheable is low. cfg_err is low for every other access.
- R9: Segment placement is as follows. The register 0 low nibble covers 80000h–9FFFFh, and its high nibble covers F0000h–FFFFFh. Registers 1 to 6 cover twelve 16 KB segments from C0000h upward, two per register, with the low nibble on the lower segment.
- R10: A write with cfg_idx equal to 7 changes nothing. Nibble bit 3 has no effect on any output.
- R11: Exactly one of route_mem and route_pci is high at all times outside reset.
- R12: A register write presented with cfg_we high is captured on the next rising clock edge. Outputs reflect the old value before that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_idx | input | 3 | Register index, 0 to 6 valid |
| cfg_wdata | input | 8 | Register write data |
| cpu_addr | input | 20 | CPU byte address |
| cpu_write | input | 1 | 1 for write access, 0 for read |
| cpu_code | input | 1 | 1 for a code-fetch read |
| route_mem | output | 1 | Access goes to system memory |
| route_pci | output | 1 | Access goes to PCI |
| cacheable | output | 1 | Access may be cached |
| cfg_err | output | 1 | Addressed segment has cache enable without read enable |

## Verification
The assertions assume that cpu_addr, cpu_write and cpu_code are stable values with no X or Z during each clock period. They make no assumption about whether a code fetch is ever flagged together with a write. The bench changes every input only on the falling edge and samples one nanosecond later, so combinational results are always settled. The bench also raises cpu_code together with cpu_write, which tests that such a combination never makes a write-protected segment cacheable.

// File: rtl/seg_attr_map.sv
module seg_attr_map #(
  parameter int NREG = 7,
  parameter int AW   = 20,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [7:0]    cfg_wdata,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_write,
  input  logic          cpu_code,
  output logic          route_mem,
  output logic          route_pci,
  output logic          cacheable,
  output logic          cfg_err
);

  localparam logic [7:0] REG0_RST = 8'h0F;

  logic [7:0]    attr_q [NREG];
  logic          in_low, in_hole, in_top, in_mid, mapped;
  logic [IW-1:0] mid_idx;
  logic [7:0]    mid_reg;
  logic [3:0]    sel;
  logic          re, we, ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) attr_q[i] <= (i == 0) ? REG0_RST : 8'h00;
    end else if (cfg_we && (int'(cfg_idx) < NREG)) begin
      attr_q[cfg_idx] <= cfg_wdata;
    end
  end

  assign in_low  = cpu_addr[AW-1 -: 3] == 3'b100;
  assign in_hole = cpu_addr[AW-1 -: 3] == 3'b101;
  assign in_top  = cpu_addr[AW-1 -: 4] == 4'hF;
  assign in_mid  = (cpu_addr[AW-1 -: 2] == 2'b11) && !in_top;
  assign mapped  = in_low || in_top || in_mid;

  assign mid_idx = IW'(1) + cpu_addr[AW-3 -: 3];
  assign mid_reg = attr_q[mid_idx];

  always_comb begin
    sel = 4'h0;
    if (in_low)      sel = attr_q[0][3:0];
    else if (in_top) sel = attr_q[0][7:4];
    else if (in_mid) sel = cpu_addr[AW-6] ? mid_reg[7:4] : mid_reg[3:0];
  end

  assign re = sel[0];
  assign we = sel[1];
  assign ce = sel[2];

  assign cfg_err = mapped && ce && !re;

  always_comb begin
    if (in_hole) begin
      route_mem = 1'b0;
      cacheable = 1'b0;
    end else if (!mapped) begin
      route_mem = 1'b1;
      cacheable = 1'b1;
    end else begin
      route_mem = cpu_write ? we : re;
      cacheable = ce && re && (we || (!cpu_write && cpu_code));
    end
  end

  assign route_pci = !route_mem;

  logic unused_bits;
  assign unused_bits = ^{cpu_addr[AW-7:0], sel[3]};

endmodule

// File: rtl/seg_attr_map_chk.sv
module seg_attr_map_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_write,
  input logic          route_mem,
  input logic          route_pci,
  input logic          cacheable,
  input logic          cfg_err
);

  p_one_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({route_mem, route_pci}));

  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[AW-1] == 1'b0) |-> (route_mem && cacheable && !cfg_err));

  p_hole_pci_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[AW-1 -: 3] == 3'b101) |-> (route_pci && !cacheable));

  p_err_nocache_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!cacheable && route_pci || !cacheable && cpu_write));

  p_cache_in_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cacheable |-> route_mem);

  p_err_read_pci_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cpu_write) |-> route_pci);

endmodule

bind seg_attr_map seg_attr_map_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
  .route_mem(route_mem), .route_pci(route_pci), .cacheable(cacheable), .cfg_err(cfg_err)
);

// File: tb/seg_attr_map_tb.sv
module seg_attr_map_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [19:0] cpu_addr = 0;
  logic        cpu_write = 0;
  logic        cpu_code = 0;
  logic        route_mem, route_pci, cacheable, cfg_err;

  int total = 0;
  int bad = 0;
  logic [7:0] m [7];

  always #4 clk = ~clk;

  seg_attr_map u_dut (.*);

  function automatic logic [3:0] nib(input logic [19:0] a);
    int k;
    if (a[19:17] == 3'b100) return m[0][3:0];
    if (a[19:16] == 4'hF)   return m[0][7:4];
    if (a[19:18] == 2'b11) begin
      k = int'((a - 20'hC0000) >> 14);
      return k[0] ? m[1 + k/2][7:4] : m[1 + k/2][3:0];
    end
    return 4'h0;
  endfunction

  task automatic expect_out(input string tag, input logic em, input logic ec, input logic ee);
    total++;
    if (route_mem !== em || route_pci !== !em || cacheable !== ec || cfg_err !== ee) begin
      bad++;
      $display("FAIL %s addr=%h wr=%b code=%b got mem=%b pci=%b c=%b e=%b exp mem=%b pci=%b c=%b e=%b",
        tag, cpu_addr, cpu_write, cpu_code, route_mem, route_pci, cacheable, cfg_err, em, !em, ec, ee);
    end
  endtask

  task automatic acc(input string tag, input logic [19:0] a, input logic wr, input logic cd);
    logic [3:0] n;
    logic em, ec, ee;
    @(negedge clk);
    cpu_addr = a; cpu_write = wr; cpu_code = cd;
    #1;
    n = nib(a);
    if (a < 20'h80000) begin em = 1; ec = 1; ee = 0; end
    else if (a[19:17] == 3'b101) begin em = 0; ec = 0; ee = 0; end
    else begin
      em = wr ? n[1] : n[0];
      ec = n[2] && n[0] && (n[1] || (!wr && cd));
      ee = n[2] && !n[0];
    end
    expect_out(tag, em, ec, ee);
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (idx < 7) m[idx] = d;
  endtask

  task automatic t_reset;
    acc("R1", 20'h80000, 0, 0); expect_out("R1 read cached", 1, 1, 0);
    acc("R1", 20'h9FFFF, 1, 0); expect_out("R1 write cached", 1, 1, 0);
    acc("R1", 20'hF0000, 0, 1); expect_out("R1 top pci", 0, 0, 0);
    acc("R1", 20'hC0000, 0, 0); expect_out("R1 mid pci", 0, 0, 0);
    acc("R1", 20'hEFFFF, 1, 0);
  endtask

  task automatic t_outside;
    acc("R2", 20'h00000, 0, 0);
    acc("R2", 20'h7FFFF, 1, 0);
    acc("R2", 20'h40000, 0, 1);
  endtask

  task automatic t_hole;
    for (int i = 0; i < 7; i++) wr_reg(3'(i), 8'h77);
    acc("R3", 20'hA0000, 0, 0); expect_out("R3 hole low", 0, 0, 0);
    acc("R3", 20'hBFFFF, 1, 1); expect_out("R3 hole high", 0, 0, 0);
    for (int i = 0; i < 7; i++) wr_reg(3'(i), 8'h00);
  endtask

  task automatic t_route;
    wr_reg(3'd1, 8'h01);
    acc("R4", 20'hC0000, 0, 0); expect_out("R4 read mem", 1, 0, 0);
    acc("R5", 20'hC0000, 1, 0); expect_out("R5 write pci", 0, 0, 0);
    acc("R9", 20'hC4000, 0, 0); expect_out("R9 upper nibble", 0, 0, 0);
    wr_reg(3'd1, 8'h20);
    acc("R5", 20'hC7FFF, 1, 0); expect_out("R5 write mem", 1, 0, 0);
    acc("R4", 20'hC4000, 0, 0); expect_out("R4 read pci", 0, 0, 0);
    wr_reg(3'd1, 8'h00);
  endtask

  task automatic t_cache;
    wr_reg(3'd2, 8'h07);
    acc("R6", 20'hC8000, 0, 0); expect_out("R6 read cached", 1, 1, 0);
    acc("R6", 20'hCBFFF, 1, 0); expect_out("R6 write cached", 1, 1, 0);
    wr_reg(3'd2, 8'h05);
    acc("R7", 20'hC8000, 0, 0); expect_out("R7 data read", 1, 0, 0);
    acc("R7", 20'hC8000, 0, 1); expect_out("R7 code read", 1, 1, 0);
    acc("R7", 20'hC8000, 1, 1); expect_out("R7 write", 0, 0, 0);
    wr_reg(3'd2, 8'h00);
  endtask

  task automatic t_err;
    wr_reg(3'd3, 8'h06);
    acc("R8", 20'hD0000, 0, 1); expect_out("R8 err read", 0, 0, 1);
    acc("R8", 20'hD0000, 1, 0); expect_out("R8 err write", 1, 0, 1);
    acc("R8", 20'hD4000, 0, 0); expect_out("R8 neighbour", 0, 0, 0);
    wr_reg(3'd3, 8'h00);
  endtask

  task automatic t_map;
    for (int s = 0; s < 12; s++) begin
      wr_reg(3'(1 + s/2), (s % 2) ? 8'h10 : 8'h01);
      for (int p = 0; p < 12; p++)
        acc("R9", 20'hC0000 + 20'(p) * 20'h4000 + 20'h1234, 0, 0);
      wr_reg(3'(1 + s/2), 8'h00);
    end
    wr_reg(3'd0, 8'h10);
    acc("R9", 20'hF8000, 0, 0); expect_out("R9 top seg", 1, 0, 0);
    acc("R9", 20'h80000, 0, 0); expect_out("R9 low seg", 0, 0, 0);
  endtask

  task automatic t_ignore;
    wr_reg(3'd7, 8'hFF);
    acc("R10", 20'hF0000, 0, 0); expect_out("R10 idx7 top", 1, 0, 0);
    acc("R10", 20'hE0000, 1, 0); expect_out("R10 idx7 mid", 0, 0, 0);
    wr_reg(3'd5, 8'h88);
    acc("R10", 20'hE0000, 0, 0); expect_out("R10 spare low", 0, 0, 0);
    acc("R10", 20'hE4000, 1, 1); expect_out("R10 spare high", 0, 0, 0);
    wr_reg(3'd5, 8'h00);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd4; cfg_wdata = 8'h03;
    cpu_addr = 20'hD8000; cpu_write = 0; cpu_code = 0;
    #1 expect_out("R12 before edge", 0, 0, 0);
    @(posedge clk);
    #1 expect_out("R12 after edge", 1, 0, 0);
    @(negedge clk);
    cfg_we = 0; m[4] = 8'h03;
    acc("R12", 20'hD8000, 1, 0); expect_out("R12 held", 1, 0, 0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog R11 got hang exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m[0] = 8'h0F;
    for (int i = 1; i < 7; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 expect_out("R1 in reset", 1, 1, 0);
    rst_n = 1;
    t_reset;
    t_outside;
    t_hole;
    t_route;
    t_cache;
    t_err;
    t_map;
    t_ignore;
    t_timing;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule